// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave end of a two-wire serial memory. A fast system clock oversamples the bus clock and data lines through two-flop synchronisers. Edges are found on the synchronised copies. A falling data line while the bus clock is high opens a transfer, and a rising data line while the clock is high closes it. The block decodes a control byte and a word address and answers on the data line through an open-drain enable, where a high enable pulls the line low. The storage is an internal 2048-byte array, seen as eight blocks of 256 bytes.

Reads come in three forms. A current-address read returns the byte at the internal pointer. A random read loads the pointer with a write-direction control byte and a word address, then takes a repeated START and a read control byte. A sequential read keeps streaming bytes for as long as the master acknowledges them.

Written bytes are not stored by this block. Each accepted byte leaves as a one-cycle strobe with its address and data, bound for a separate page-buffer and write-cycle block. That block commits bytes into the array through a write port and raises a busy input while it programs. While busy is high, the slave gives no acknowledge at all.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A START (data falls while clock high) aborts whatever is in progress, releases the data line and begins a new control byte. A STOP (data rises while clock high) releases the line and returns the slave to idle.
- R2: A control byte whose upper four bits are 1010 is acknowledged. Bits 3..1 select the block and bit 0 is the direction (1 = read). Any other upper nibble gets no acknowledge, and the slave then stays silent until the next START.
- R3: The slave changes its data-line drive only while the synchronised bus clock is low. Read data is therefore stable through each clock high period, one bit per pulse, most significant bit first.
- R4: After a write control byte, the next byte sets the pointer to {block select, byte}. Each further acknowledged byte produces exactly one single-cycle write strobe carrying the pointer and the byte, and the pointer then advances by one.
- R5: A random read returns the array byte at {block select, word address}.
- R6: A read control byte leaves the pointer unchanged and its block bits are not used. The first byte returned is the one at the pointer, which already points one past the last byte read or written.
- R7: In a sequential read, each acknowledged byte is followed by the byte at the next address. The address wraps from 0x7FF to 0x000.
- R8: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until a START.
- R9: While the busy input is high at the end of a received byte, the slave does not acknowledge it, raises no write strobe and returns to idle.
- R10: An acknowledge is the data line held low by the slave for the ninth clock pulse after a received byte. It is released after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled from the pin |
| sda_i | input | 1 | Bus data line as sampled from the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| prog_busy | input | 1 | High while the write-cycle block is programming |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 11 | Array address of the accepted byte |
| wr_data | output | 8 | Accepted byte |
| commit_we | input | 1 | Write enable from the write-cycle block into the array |
| commit_addr | input | 11 | Array address to commit |
| commit_data | input | 8 | Byte to commit |

## Verification
The array is first filled with an arithmetic pattern, so every expected byte is a function of its address. Random reads visit the first, a middle and the last byte of all eight blocks. These reads separate block-select decoding from word-address decoding. A long sequential read and a short one across the top address show whether the pointer advances, and whether it wraps rather than saturates. Current-address reads after reads, after writes and after an aborted transfer show whether the pointer carries over between transfers. Wrong control prefixes, the busy input raised at the control byte and at a data byte, master not-acknowledge and a START in mid-byte each tell a silent slave from one that still drives, acknowledges or writes.

// File: rtl/sep_pkg.sv
// Shared types and constants for the serial EEPROM slave.
// Assumes byte-oriented transfers with one acknowledge slot per byte.
package sep_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } sep_state_t;
endpackage

// File: rtl/sep_line_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes STAGES >= 2; resets to RST_VAL (idle bus level).
module sep_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Build the flop chain stage by stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= raw_i;
            end
        end else begin : g_next
            // Later stages re-time the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/sep_bus_events.sv
// Synchronises the bus clock and data lines and derives clock edges,
// START and STOP. Assumes the bus clock is slower than clk by several
// cycles per phase so every edge is seen.
module sep_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_p, sda_p;

    sep_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .sync_o(scl_s)
    );
    sep_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .sync_o(sda_s)
    );

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Classify the current pair of samples into bus events.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/sep_mem_array.sv
// Byte array with one write port and one registered read port.
// Assumes reads are issued many cycles before the data is needed.
module sep_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a byte from the write-cycle block.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the byte at the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sep_proto_fsm.sv
// Protocol engine: receives control, address and data bytes, drives
// acknowledges and read data, keeps the address pointer.
// Assumes clean edge strobes from sep_bus_events and that rd_data
// follows ptr well before a byte is loaded for transmission.
module sep_proto_fsm
    import sep_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter logic [3:0] CTRL_PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              prog_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output sep_state_t        st
);
    localparam int BLK_W = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx;
    logic [BLK_W-1:0]  blk;
    logic              rd_mode;
    logic              nack;

    // Sequence the bus protocol one event at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sr       <= '0;
            tx       <= '0;
            blk      <= '0;
            rd_mode  <= 1'b0;
            nack     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (bus_start) begin
                st     <= ST_CTRL;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_CTRL, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            cnt <= '0;
                            if (prog_busy) begin
                                st <= ST_IDLE;
                            end else if (st == ST_CTRL) begin
                                if (sr[BYTE_W-1 -: 4] == CTRL_PREFIX) begin
                                    sda_oe  <= 1'b1;
                                    blk     <= sr[BLK_W:1];
                                    rd_mode <= sr[0];
                                    st      <= ST_CTRL_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_WADDR) begin
                                sda_oe <= 1'b1;
                                ptr    <= {blk, sr};
                                st     <= ST_WADDR_ACK;
                            end else begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= sr;
                                ptr      <= ptr + 1'b1;
                                st       <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                st     <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            st     <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                st     <= ST_RACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (!nack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                st     <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_eeprom_slave.sv
// Top of the two-wire serial EEPROM slave: bus event detection,
// protocol engine and the internal byte array. Writes leave as strobes
// and come back through the commit port once programmed.
module serial_eeprom_slave #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              prog_busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              commit_we,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [7:0]        commit_data
);
    import sep_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall;
    logic              bus_start, bus_stop;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    sep_state_t        fsm_st;

    sep_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    sep_proto_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .bus_start(bus_start), .bus_stop(bus_stop),
        .prog_busy(prog_busy), .rd_data(rd_data), .ptr(ptr),
        .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .st(fsm_st)
    );

    sep_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(commit_we), .waddr(commit_addr),
        .wdata(commit_data), .raddr(ptr), .rdata(rd_data)
    );
endmodule

// File: rtl/sep_checker.sv
// Protocol properties of the serial EEPROM slave, bound to its top.
module sep_checker
    import sep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       sda_oe,
    input logic       wr_valid,
    input logic       prog_busy,
    input sep_state_t st
);
    logic ack_st;
    assign ack_st = (st == ST_CTRL_ACK) || (st == ST_WADDR_ACK) || (st == ST_WDATA_ACK);

    p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_oe);
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);
    p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    p_rack_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe);
    p_no_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(prog_busy));
    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && ack_st) |-> !$past(prog_busy));
endmodule

bind serial_eeprom_slave sep_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_start(bus_start),
    .bus_stop(bus_stop), .sda_oe(sda_oe), .wr_valid(wr_valid),
    .prog_busy(prog_busy), .st(fsm_st)
);

// File: tb/serial_eeprom_slave_tb.sv
// Self-checking bench: a bit-level bus master, an arithmetic memory
// image and a loop-back standing in for the write-cycle block.
module serial_eeprom_slave_tb;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int Q     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic prog_busy = 1'b0;
    logic init_mode = 1'b1;
    logic init_we = 1'b0;
    logic [AW-1:0] init_addr = '0;
    logic [7:0] init_data = '0;

    logic sda_oe, wr_valid, sda_line;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic cm_we;
    logic [AW-1:0] cm_addr;
    logic [7:0] cm_data;

    logic [7:0] exp_mem [DEPTH];
    int exp_ptr = 0;
    int wr_count = 0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign cm_we   = init_mode ? init_we   : wr_valid;
    assign cm_addr = init_mode ? init_addr : wr_addr;
    assign cm_data = init_mode ? init_data : wr_data;

    serial_eeprom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .prog_busy(prog_busy), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit_we(cm_we),
        .commit_addr(cm_addr), .commit_data(cm_data)
    );

    always @(posedge clk) if (rst_n && wr_valid) wr_count <= wr_count + 1;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 73 + (a >> 3)) ^ 8'h5A);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; waitq();
        scl_m = 1'b1; waitq();
        r = sda_line; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            d[i] = r;
        end
        clk_bit(~mack, r);
    endtask

    // Random read of count bytes starting at addr; checks each byte.
    task automatic rand_read(input int addr, input int count, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, 3'(addr >> 8), 1'b0}, ack);
        chk(ack, {tag, " R2 R10 ctrl ack"}, ack, 1);
        send_byte(8'(addr), ack);
        chk(ack, {tag, " R10 addr ack"}, ack, 1);
        bus_start();
        send_byte({4'b1010, 3'(addr >> 8), 1'b1}, ack);
        chk(ack, {tag, " R2 read ctrl ack"}, ack, 1);
        for (int i = 0; i < count; i++) begin
            int a = (addr + i) % DEPTH;
            read_byte(i != count - 1, d);
            chk(d == exp_mem[a], {tag, " R3 data"}, d, exp_mem[a]);
        end
        bus_stop();
        exp_ptr = (addr + count) % DEPTH;
    endtask

    task automatic cur_read(input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hAF, ack);
        chk(ack, {tag, " R2 ctrl ack"}, ack, 1);
        read_byte(1'b0, d);
        chk(d == exp_mem[exp_ptr], {tag, " R6 current read"}, d, exp_mem[exp_ptr]);
        bus_stop();
        exp_ptr = (exp_ptr + 1) % DEPTH;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack, r, quiet;
        logic [7:0] d;
        int wc;
        // Fill the array through the commit port.
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            init_we = 1'b1; init_addr = AW'(a); init_data = pat(a);
            exp_mem[a] = pat(a);
        end
        @(negedge clk); init_we = 1'b0; init_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset state", {sda_oe, wr_valid}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: wrong prefixes get no acknowledge; slave stays silent.
        bus_start();
        send_byte(8'hB2, ack);
        chk(!ack, "R2 prefix 1011 nack", ack, 0);
        send_byte(8'hA0, ack);
        chk(!ack, "R2 silent until START", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h20, ack);
        chk(!ack, "R2 prefix 0010 nack", ack, 0);
        bus_stop();

        // R5: random reads at the edges and middle of every block.
        for (int b = 0; b < 8; b++) begin
            rand_read(b * 256 + 0,   1, "R5 blk first");
            rand_read(b * 256 + 90,  1, "R5 blk mid");
            rand_read(b * 256 + 255, 1, "R5 blk last");
            cur_read("R6 after read");
        end

        // R7: sequential read through a block and across the top address.
        rand_read(3 * 256 + 17, 256, "R7 long seq");
        rand_read(12'h7F8, 16, "R7 wrap");
        cur_read("R6 after wrap");

        // R4: write five bytes crossing a block boundary.
        wc = wr_count;
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        chk(ack, "R4 write ctrl ack", ack, 1);
        send_byte(8'hFD, ack);
        chk(ack, "R4 write addr ack", ack, 1);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] v = 8'(8'hC3 + i * 17);
            send_byte(v, ack);
            chk(ack, "R4 data ack", ack, 1);
            exp_mem[(12'h5FD + i) % DEPTH] = v;
        end
        bus_stop();
        repeat (4) @(negedge clk);
        chk(wr_count == wc + 5, "R4 strobe count", wr_count - wc, 5);
        exp_ptr = 12'h5FD + 5;
        cur_read("R6 after write");
        rand_read(12'h5FD, 5, "R4 readback");

        // R9: busy at the control byte.
        prog_busy = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R9 busy ctrl nack", ack, 0);
        bus_stop();
        prog_busy = 1'b0;
        // R9: busy at a data byte: no acknowledge, no strobe.
        wc = wr_count;
        bus_start();
        send_byte({4'b1010, 3'd2, 1'b0}, ack);
        send_byte(8'h40, ack);
        chk(ack, "R9 addr ack when idle", ack, 1);
        prog_busy = 1'b1;
        send_byte(8'h00, ack);
        chk(!ack, "R9 busy data nack", ack, 0);
        prog_busy = 1'b0;
        bus_stop();
        repeat (4) @(negedge clk);
        chk(wr_count == wc, "R9 no strobe", wr_count - wc, 0);
        rand_read(12'h240, 1, "R9 unchanged");

        // R8: after master not-acknowledge the line stays released.
        rand_read(12'h123, 2, "R8 read");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, r);
            if (!r) quiet = 1'b0;
        end
        chk(quiet, "R8 released after nack", quiet, 1);
        bus_stop();

        // R1: a START in mid-byte aborts the address and begins a read.
        bus_start();
        send_byte(8'hA0, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
        send_byte(8'hA1, ack);
        chk(ack, "R1 restart ctrl ack", ack, 1);
        read_byte(1'b0, d);
        chk(d == exp_mem[exp_ptr], "R1 pointer kept", d, exp_mem[exp_ptr]);
        bus_stop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule